// File: doc/BRIEF.md
# Four-Channel Shared-Divider PWM Controller

This block drives four pulse-width-modulated outputs from a small memory-mapped register set. Four independent timebase generators each divide the input clock by a programmable 16-bit factor D and count the resulting ticks through a 256-step frame. Each output channel names one generator through a 2-bit select field. It is high while that generator's step count is below the channel's 8-bit duty value. One frame therefore lasts 256 × D clocks, and the output is high for duty × D of them, at the start of the frame.

Software programs a generator's divider, a channel's duty and select, and then sets the channel's enable and the generator's run bits. A per-channel force bit holds an enabled output at a constant high, which covers the full-on case that an 8-bit duty cannot reach. New divider and duty values act on the next clock. The frame in progress is not finished first. Several channels may share one generator and so stay phase-aligned.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: While reset is applied, and after it is released, every register reads zero and every PWM output is low.
- R2: Register words: control at byte 0x000 (bits 3:0 channel enables, bits 11:8 channel force-high), run at 0x004 (bits 3:0 generator run), divider n at 0x008+4n (bits 15:0), duty n at 0x018+4n (bits 7:0 duty, bits 9:8 generator select). Unused bits read zero. Read data appears in the cycle after the read strobe and is zero in any cycle that follows no read.
- R3: With its channel enabled, force clear and a running generator with divider D ≥ 1, an output is high for exactly duty × D clocks in every 256 × D clock window. The output is registered: it reflects the state one clock earlier.
- R4: A channel whose enable bit is clear drives a low output, whatever its duty, select or force bit.
- R5: An enabled channel with its force bit set drives a constant high output.
- R6: A channel compares its duty only against the step count of the generator named by its select field. Generators run independently, and channels may share one.
- R7: A generator whose run bit is clear holds its counters, so every channel using it keeps a constant output.
- R8: A generator with divider 0 is stopped. A channel that selects it drives low unless its force bit is set.
- R9: A new duty or divider value changes the output within two clocks of the write. The current frame is not allowed to finish first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle after bus_rd |
| pwm_out | output | 4 | PWM outputs, one per channel |

## Verification
A table of eight configurations varies the channel, the selected generator, the divider (1 to 3) and the duty (0, 1, mid-range, 255). For each one the bench counts high cycles over one full frame after settling, which separates a wrong compare width from a wrong divider pace or a wrong select decode. The same window confirms that the other, disabled channels stay low. Directed cases cover a very slow divider: a duty raised in the middle of a frame must show at once, and a divider dropped from 1000 to 1 must pull the low phase forward by about a frame. Further cases cover a stopped generator holding the output still, a zero divider with and without force, and register readback with the unused bits masked.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  // Byte offsets of the register words; the bus decode depends on them.
  localparam int unsigned CTRL_OFS = 32'h000;
  localparam int unsigned RUN_OFS  = 32'h004;
  localparam int unsigned DIV_OFS  = 32'h008;
  localparam int unsigned DUTY_OFS = 32'h018;

  // Bit position of the first force-high bit in the control word.
  localparam int unsigned FORCE_LSB = 8;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_CTRL,
    KIND_RUN,
    KIND_DIV,
    KIND_DUTY
  } reg_kind_e;

endpackage

// File: rtl/pwm_quad_rst_sync.sv
module pwm_quad_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 16,
  parameter int DUTY_W = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  output logic [DATA_W-1:0]               bus_rdata,
  output logic [NUM_CH-1:0]               ch_en,
  output logic [NUM_CH-1:0]               ch_force,
  output logic [NUM_CH-1:0]               gen_run,
  output logic [NUM_CH-1:0][DIV_W-1:0]    gen_div,
  output logic [NUM_CH-1:0][DUTY_W-1:0]   ch_duty,
  output logic [NUM_CH-1:0][$clog2(NUM_CH)-1:0] ch_sel
);

  localparam int SEL_W      = $clog2(NUM_CH);
  localparam int WA         = ADDR_W - 2;
  localparam int CTRL_WORD  = CTRL_OFS / 4;
  localparam int RUN_WORD   = RUN_OFS / 4;
  localparam int DIV_WORD0  = DIV_OFS / 4;
  localparam int DUTY_WORD0 = DUTY_OFS / 4;

  logic [WA-1:0] word;
  reg_kind_e     kind;
  logic [SEL_W-1:0] idx;

  logic [NUM_CH-1:0]             en_q, en_d;
  logic [NUM_CH-1:0]             force_q, force_d;
  logic [NUM_CH-1:0]             run_q, run_d;
  logic [NUM_CH-1:0][DIV_W-1:0]  div_q, div_d;
  logic [NUM_CH-1:0][DUTY_W-1:0] duty_q, duty_d;
  logic [NUM_CH-1:0][SEL_W-1:0]  sel_q, sel_d;
  logic [DATA_W-1:0]             rd_mux, rdata_q, rdata_d;
  logic                          unused_bits;

  assign word        = bus_addr[ADDR_W-1:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  // Address decode into a register kind and a channel index.
  always_comb begin
    kind = KIND_NONE;
    idx  = '0;
    if (word == WA'(CTRL_WORD)) begin
      kind = KIND_CTRL;
    end else if (word == WA'(RUN_WORD)) begin
      kind = KIND_RUN;
    end else if ((word >= WA'(DIV_WORD0)) && (word < WA'(DIV_WORD0 + NUM_CH))) begin
      kind = KIND_DIV;
      idx  = SEL_W'(word - WA'(DIV_WORD0));
    end else if ((word >= WA'(DUTY_WORD0)) && (word < WA'(DUTY_WORD0 + NUM_CH))) begin
      kind = KIND_DUTY;
      idx  = SEL_W'(word - WA'(DUTY_WORD0));
    end
  end

  // Next-state of the register file.
  always_comb begin
    en_d    = en_q;
    force_d = force_q;
    run_d   = run_q;
    div_d   = div_q;
    duty_d  = duty_q;
    sel_d   = sel_q;
    case (kind)
      KIND_CTRL: begin
        en_d    = bus_wdata[NUM_CH-1:0];
        force_d = bus_wdata[FORCE_LSB +: NUM_CH];
      end
      KIND_RUN: begin
        run_d = bus_wdata[NUM_CH-1:0];
      end
      KIND_DIV: begin
        div_d[idx] = bus_wdata[DIV_W-1:0];
      end
      KIND_DUTY: begin
        duty_d[idx] = bus_wdata[DUTY_W-1:0];
        sel_d[idx]  = bus_wdata[DUTY_W +: SEL_W];
      end
      default: begin
      end
    endcase
  end

  // Read multiplexer.
  always_comb begin
    rd_mux = '0;
    case (kind)
      KIND_CTRL: begin
        rd_mux[NUM_CH-1:0]            = en_q;
        rd_mux[FORCE_LSB +: NUM_CH]   = force_q;
      end
      KIND_RUN: begin
        rd_mux[NUM_CH-1:0] = run_q;
      end
      KIND_DIV: begin
        rd_mux[DIV_W-1:0] = div_q[idx];
      end
      KIND_DUTY: begin
        rd_mux[DUTY_W-1:0]       = duty_q[idx];
        rd_mux[DUTY_W +: SEL_W]  = sel_q[idx];
      end
      default: begin
      end
    endcase
    rdata_d = bus_rd ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      force_q <= '0;
      run_q   <= '0;
      div_q   <= '0;
      duty_q  <= '0;
      sel_q   <= '0;
    end else if (bus_wr) begin
      en_q    <= en_d;
      force_q <= force_d;
      run_q   <= run_d;
      div_q   <= div_d;
      duty_q  <= duty_d;
      sel_q   <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign ch_en     = en_q;
  assign ch_force  = force_q;
  assign gen_run   = run_q;
  assign gen_div   = div_q;
  assign ch_duty   = duty_q;
  assign ch_sel    = sel_q;

endmodule

// File: rtl/pwm_quad_tick.sv
module pwm_quad_tick #(
  parameter int DIV_W  = 16,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  div,
  output logic [STEP_W-1:0] step,
  output logic              live
);

  logic [DIV_W-1:0]  pre_q, pre_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              advance;
  logic              wrap;

  assign live    = (div != '0);
  assign advance = run && live;
  // A divider lowered below the running count wraps at once.
  assign wrap    = (pre_q >= (div - 1'b1));

  always_comb begin
    pre_d  = pre_q;
    step_d = step_q;
    if (wrap) begin
      pre_d  = '0;
      step_d = step_q + 1'b1;
    end else begin
      pre_d  = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
    end else if (advance) begin
      pre_q  <= pre_d;
      step_q <= step_d;
    end
  end

  assign step = step_q;

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
  parameter int NUM_CH = 4,
  parameter int STEP_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en,
  input  logic                            force_hi,
  input  logic [STEP_W-1:0]               duty,
  input  logic [$clog2(NUM_CH)-1:0]       sel,
  input  logic [NUM_CH-1:0][STEP_W-1:0]   steps,
  input  logic [NUM_CH-1:0]               lives,
  output logic                            pwm
);

  logic [STEP_W-1:0] cur_step;
  logic              cur_live;
  logic              pwm_q, pwm_d;

  assign cur_step = steps[sel];
  assign cur_live = lives[sel];

  always_comb begin
    pwm_d = en && (force_hi || (cur_live && (cur_step < duty)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
    end
  end

  assign pwm = pwm_q;

endmodule

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl #(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 16,
  parameter int DUTY_W = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int SEL_W = $clog2(NUM_CH);

  logic                          rst_sync_n;
  logic [NUM_CH-1:0]             ch_en;
  logic [NUM_CH-1:0]             ch_force;
  logic [NUM_CH-1:0]             gen_run;
  logic [NUM_CH-1:0][DIV_W-1:0]  gen_div;
  logic [NUM_CH-1:0][DUTY_W-1:0] ch_duty;
  logic [NUM_CH-1:0][SEL_W-1:0]  ch_sel;
  logic [NUM_CH-1:0][DUTY_W-1:0] gen_step;
  logic [NUM_CH-1:0]             gen_live;

  pwm_quad_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_quad_regs #(
    .NUM_CH (NUM_CH),
    .DIV_W  (DIV_W),
    .DUTY_W (DUTY_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .ch_en     (ch_en),
    .ch_force  (ch_force),
    .gen_run   (gen_run),
    .gen_div   (gen_div),
    .ch_duty   (ch_duty),
    .ch_sel    (ch_sel)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_gen
    pwm_quad_tick #(
      .DIV_W  (DIV_W),
      .STEP_W (DUTY_W)
    ) u_tick (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .run   (gen_run[g]),
      .div   (gen_div[g]),
      .step  (gen_step[g]),
      .live  (gen_live[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_quad_chan #(
      .NUM_CH (NUM_CH),
      .STEP_W (DUTY_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .en       (ch_en[c]),
      .force_hi (ch_force[c]),
      .duty     (ch_duty[c]),
      .sel      (ch_sel[c]),
      .steps    (gen_step),
      .lives    (gen_live),
      .pwm      (pwm_out[c])
    );
  end

endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 16,
  parameter int DUTY_W = 8,
  parameter int DATA_W = 32
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [NUM_CH-1:0]                     ch_en,
  input logic [NUM_CH-1:0]                     ch_force,
  input logic [NUM_CH-1:0]                     gen_run,
  input logic [NUM_CH-1:0][DIV_W-1:0]          gen_div,
  input logic [NUM_CH-1:0][$clog2(NUM_CH)-1:0] ch_sel,
  input logic [NUM_CH-1:0][DUTY_W-1:0]         gen_step,
  input logic                                  bus_rd,
  input logic [DATA_W-1:0]                     bus_rdata,
  input logic [NUM_CH-1:0]                     pwm_out
);

  // R1: outputs low while the internal reset is applied
  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |-> (pwm_out == '0));

  // R2: read data is zero after a cycle without a read strobe
  assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assert_off_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |=> !pwm_out[i]);

    assert_force_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[i] && ch_force[i]) |=> pwm_out[i]);

    assert_stopped_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[i] && !ch_force[i] && (gen_div[ch_sel[i]] == '0)) |=> !pwm_out[i]);

    assert_hold_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_run[i] |=> $stable(gen_step[i]));
  end

endmodule

bind pwm_quad_ctrl pwm_quad_chk #(
  .NUM_CH (NUM_CH),
  .DIV_W  (DIV_W),
  .DUTY_W (DUTY_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ch_en     (ch_en),
  .ch_force  (ch_force),
  .gen_run   (gen_run),
  .gen_div   (gen_div),
  .ch_sel    (ch_sel),
  .gen_step  (gen_step),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pwm_out   (pwm_out)
);

// File: tb/pwm_quad_ctrl_tb.sv
module pwm_quad_ctrl_tb;

  localparam int WATCHDOG = 150000;
  localparam int NV       = 8;

  typedef struct packed {
    logic [1:0]  ch;
    logic [1:0]  gen;
    logic [15:0] div;
    logic [7:0]  duty;
    logic [15:0] exp_hi;
  } vec_t;

  // channel, generator, divider, duty, expected high clocks per frame
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 16'd1, 8'd0,   16'd0},
    '{2'd0, 2'd0, 16'd1, 8'd128, 16'd128},
    '{2'd1, 2'd1, 16'd2, 8'd64,  16'd128},
    '{2'd2, 2'd3, 16'd3, 8'd255, 16'd765},
    '{2'd3, 2'd2, 16'd1, 8'd1,   16'd1},
    '{2'd1, 2'd2, 16'd2, 8'd200, 16'd400},
    '{2'd3, 2'd0, 16'd3, 8'd17,  16'd51},
    '{2'd2, 2'd1, 16'd2, 8'd100, 16'd200}
  };

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  pwm_quad_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    d        = bus_rdata;
  endtask

  task automatic run_vectors();
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int   hi;
      int   others;
      int   win;
      t      = VECS[v];
      hi     = 0;
      others = 0;
      win    = 256 * int'(t.div);
      wr(12'h000, 32'h1 << t.ch);
      wr(12'h008 + 12'(4 * int'(t.gen)), {16'h0, t.div});
      wr(12'h018 + 12'(4 * int'(t.ch)), {22'h0, t.gen, t.duty});
      wait_clk(win + 8);
      for (int k = 0; k < win; k++) begin
        @(negedge clk);
        if (pwm_out[t.ch]) hi++;
        if ((pwm_out & ~(4'b0001 << t.ch)) != 4'b0000) others++;
      end
      // R3 high time per frame, R6 generator select
      check($sformatf("R3/R6 vec%0d high clocks", v), 32'(hi), {16'h0, t.exp_hi});
      // R4 disabled channels stay low
      check($sformatf("R4 vec%0d other outputs", v), 32'(others), 32'd0);
    end
  endtask

  initial begin
    logic [31:0] d;
    int          cnt;
    logic        first;
    logic        moved;
    logic        seen_low;

    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    wait_clk(3);
    check("R1 outputs in reset", {28'h0, pwm_out}, 32'h0);
    rst_n = 1'b1;
    wait_clk(4);

    // R1 reset state
    check("R1 outputs after reset", {28'h0, pwm_out}, 32'h0);
    rd(12'h000, d); check("R1 control reads zero", d, 32'h0);
    rd(12'h00C, d); check("R1 divider reads zero", d, 32'h0);
    rd(12'h020, d); check("R1 duty reads zero", d, 32'h0);

    // R2 readback with unused bits masked
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, d); check("R2 control readback", d, 32'h0000_0F0F);
    @(negedge clk); check("R2 idle read data", bus_rdata, 32'h0);
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, d); check("R2 run readback", d, 32'h0000_000F);
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h00C, d); check("R2 divider readback", d, 32'h0000_FFFF);
    wr(12'h024, 32'hFFFF_FFFF);
    rd(12'h024, d); check("R2 duty readback", d, 32'h0000_03FF);

    // table walk
    do_reset();
    wr(12'h004, 32'h0000_000F);
    run_vectors();

    // R4 disabled but force set and full duty: still low
    wr(12'h000, 32'h0000_0100);
    wr(12'h018, 32'h0000_00FF);
    wr(12'h008, 32'h0000_0001);
    cnt = 0;
    for (int k = 0; k < 300; k++) begin @(negedge clk); if (pwm_out[0]) cnt++; end
    check("R4 disabled with force", 32'(cnt), 32'd0);

    // R5 force high with zero duty
    wr(12'h018, 32'h0000_0000);
    wr(12'h000, 32'h0000_0101);
    wait_clk(2);
    cnt = 0;
    for (int k = 0; k < 300; k++) begin @(negedge clk); if (pwm_out[0]) cnt++; end
    check("R5 forced high clocks", 32'(cnt), 32'd300);

    // R8 zero divider from a fresh reset: low, then forced high
    do_reset();
    wr(12'h018, 32'h0000_0064);
    wr(12'h004, 32'h0000_0001);
    wr(12'h000, 32'h0000_0001);
    cnt = 0;
    for (int k = 0; k < 512; k++) begin @(negedge clk); if (pwm_out[0]) cnt++; end
    check("R8 zero divider low", 32'(cnt), 32'd0);
    wr(12'h000, 32'h0000_0101);
    wait_clk(2);
    check("R8 zero divider with force", {31'h0, pwm_out[0]}, 32'h1);

    // R9 immediate duty and divider update on a slow frame
    do_reset();
    wr(12'h008, 32'd1000);
    wr(12'h018, 32'h0000_0000);
    wr(12'h004, 32'h0000_0001);
    wr(12'h000, 32'h0000_0001);
    wait_clk(5000);
    check("R9 low before duty write", {31'h0, pwm_out[0]}, 32'h0);
    wr(12'h018, 32'h0000_00FF);
    wait_clk(2);
    check("R9 duty acts at once", {31'h0, pwm_out[0]}, 32'h1);
    wr(12'h018, 32'h0000_00C8);
    wr(12'h008, 32'd1);
    seen_low = 1'b0;
    for (int k = 0; k < 260; k++) begin @(negedge clk); if (!pwm_out[0]) seen_low = 1'b1; end
    check("R9 divider acts at once", {31'h0, seen_low}, 32'h1);

    // R7 stopped generator freezes output
    wr(12'h004, 32'h0000_0000);
    wait_clk(2);
    first = pwm_out[0];
    moved = 1'b0;
    for (int k = 0; k < 600; k++) begin @(negedge clk); if (pwm_out[0] != first) moved = 1'b1; end
    check("R7 output frozen while stopped", {31'h0, moved}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule